// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave that gives a host controller read and write access to a small bank of 8-bit control registers. It also presents the register contents to the rest of the chip as parallel fields. The host drives an active-low select, a serial clock and a data line. The block returns read data either on that same data line (3-wire operation) or on a dedicated data-out line (4-wire operation). A bit in the common settings register picks which of the two is used. All port inputs are synchronised into the local clock domain. Serial clock edges are detected there.

Every transfer opens with an instruction byte that carries the direction and a 5-bit starting address. Any number of data bytes may follow while select stays low. After each data byte the address steps down by one, so a burst fills or reads a block of registers from the top down. The bank holds seven registers:

| Address | Register |
|---|---|
| 00h | common settings |
| 01h | transmit configuration |
| 02h | PLL configuration |
| 03h to 06h | oscillator frequency word, least significant byte at 03h |

The control engine is a four-state machine:

| State | Meaning | Transitions |
|---|---|---|
| ST_IDLE | waits for select | goes to ST_INSTR once select is seen low |
| ST_INSTR | shifts in the instruction | after the eighth sampled bit, goes to ST_READ if the direction bit is 1, else to ST_WRITE |
| ST_WRITE | shifts data bytes into the bank | stays until select rises, then returns to ST_IDLE |
| ST_READ | shifts register bytes out | stays until select rises, then returns to ST_IDLE |

From every state, select going high forces a return to ST_IDLE.

Top module: `spi_cfg_port`

## Requirements
- R1: The instruction byte is sent MSB first and sampled on rising serial clock edges. Bit 7 = 1 means read and 0 means write. Bits 4:0 are the start address. Bits 6:5 are ignored.
- R2: Read data is launched on falling serial clock edges, MSB first. The first bit appears on the falling edge that follows the instruction's last rising edge.
- R3: In a burst, the first data byte uses the start address and each following byte uses the next lower address. This holds for both writes and reads.
- R4: Counting down from address 00h continues at 1Fh.
- R5: Only addresses 00h to 06h hold registers. Any other address reads back as 00h, and a write to it changes nothing.
- R6: Select going high ends the transfer. A data byte with fewer than eight bits clocked in is discarded without a write. While select is high, no read line is driven.
- R7: An active-low reset loads the defaults: 00h=00h, 01h=87h, 02h=10h, 03h=11h, 04h=22h, 05h=33h, 06h=44h.
- R8: Bit 7 of register 00h selects the read path. When it is 1 (3-wire), read bits appear on sdio_out with sdio_oe high and sdo held 0. When it is 0 (4-wire), read bits appear on sdo and sdio_oe stays low.
- R9: The parallel outputs follow the registers. common_cfg is 00h, tx_cfg is 01h and pll_cfg is 02h. nco_freq is {06h,05h,04h,03h}. A register takes a written byte at the rising edge that completes that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | local clock, samples all serial inputs |
| rst_n | input | 1 | active-low asynchronous reset |
| cs_n | input | 1 | active-low transfer select |
| sclk | input | 1 | serial clock from the host |
| sdio_in | input | 1 | data from the host on the shared line |
| sdio_out | output | 1 | read data onto the shared line in 3-wire operation |
| sdio_oe | output | 1 | drive enable of the shared line |
| sdo | output | 1 | read data on the separate line in 4-wire operation |
| common_cfg | output | 8 | contents of register 00h |
| tx_cfg | output | 8 | contents of register 01h |
| pll_cfg | output | 8 | contents of register 02h |
| nco_freq | output | 32 | oscillator frequency word from registers 06h..03h |

## Verification
The register bank is swept over every address from 01h to 1Fh with an address-dependent byte, first written and then read back. This separates mapped storage from the unmapped range and exposes address decoding slips.

Descending bursts are checked in several ways:
- a burst read of the reset values shows byte order and defaults together;
- a burst write assembles a full frequency word, which shows the step direction;
- bursts that start at 00h or 01h cross into 1Fh, which shows the wrap.

Truncated bytes, instructions with the ignored bits set, and reads in both line modes each test one rule on their own. The line-mode reads also tell a wrong output line apart from a wrong enable.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 5;
    localparam int NCO_BYTES = 4;
    localparam int NUM_REGS  = 3 + NCO_BYTES;
    localparam int REG_COMMON = 0;
    localparam int REG_TX     = 1;
    localparam int REG_PLL    = 2;
    localparam int REG_NCO0   = 3;
    localparam int MODE_BIT   = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INSTR = 2'd1,
        ST_WRITE = 2'd2,
        ST_READ  = 2'd3
    } xfer_state_t;

    // reset value of register idx; frequency bytes are 11h times their rank
    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        logic [DATA_W-1:0] v;
        if (idx == REG_COMMON)      v = 8'h00;
        else if (idx == REG_TX)     v = 8'h87;
        else if (idx == REG_PLL)    v = 8'h10;
        else                        v = DATA_W'((idx - REG_NCO0 + 1) * 17);
        return v;
    endfunction

endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile
    import spi_cfg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          waddr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [ADDR_W-1:0]          raddr,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= reg_default(g);
            else if (we && waddr == ADDR_W'(g))
                q <= wdata;
        end
        assign regs_flat[g*DATA_W +: DATA_W] = q;
    end

    // unmapped addresses fall through to zero
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (raddr == ADDR_W'(i)) rdata = regs_flat[i*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/spi_cfg_engine.sv
module spi_cfg_engine
    import spi_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr,
    output logic              we,
    output logic [DATA_W-1:0] wdata,
    output logic              out_bit,
    output logic              reading
);
    localparam int CNT_W = $clog2(DATA_W);

    xfer_state_t       state_q, state_d;
    logic              sclk_q;
    logic [DATA_W-2:0] rx_sh, tx_sh;
    logic [CNT_W-1:0]  rx_cnt, tx_cnt;
    logic              rise, fall, byte_done;
    logic [DATA_W-1:0] full_byte;

    assign rise      = sclk_s & ~sclk_q;
    assign fall      = ~sclk_s & sclk_q;
    assign byte_done = rise && (rx_cnt == CNT_W'(DATA_W - 1));
    assign full_byte = {rx_sh, mosi_s};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (cs_n_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_INSTR;
                ST_INSTR: if (byte_done)
                              state_d = full_byte[DATA_W-1] ? ST_READ : ST_WRITE;
                ST_WRITE: state_d = ST_WRITE;
                ST_READ:  state_d = ST_READ;
            endcase
        end
    end

    // outputs
    always_comb begin
        we      = (state_q == ST_WRITE) && byte_done && !cs_n_s;
        wdata   = full_byte;
        reading = (state_q == ST_READ);
    end

    // shift, count and address datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            rx_cnt  <= '0;
            tx_cnt  <= '0;
            addr    <= '0;
            out_bit <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            if (state_q == ST_IDLE || cs_n_s) begin
                rx_cnt  <= '0;
                tx_cnt  <= '0;
                out_bit <= 1'b0;
            end else begin
                if (rise) begin
                    rx_sh  <= full_byte[DATA_W-2:0];
                    rx_cnt <= rx_cnt + CNT_W'(1);
                    if (byte_done && state_q == ST_INSTR)
                        addr <= full_byte[ADDR_W-1:0];
                    if (byte_done && state_q == ST_WRITE)
                        addr <= addr - ADDR_W'(1);
                end
                if (fall && state_q == ST_READ) begin
                    if (tx_cnt == '0) begin
                        out_bit <= rdata[DATA_W-1];
                        tx_sh   <= rdata[DATA_W-2:0];
                    end else begin
                        out_bit <= tx_sh[DATA_W-2];
                        tx_sh   <= {tx_sh[DATA_W-3:0], 1'b0};
                    end
                    tx_cnt <= tx_cnt + CNT_W'(1);
                    if (tx_cnt == CNT_W'(DATA_W - 1))
                        addr <= addr - ADDR_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
    import spi_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n,
    input  logic                      sclk,
    input  logic                      sdio_in,
    output logic                      sdio_out,
    output logic                      sdio_oe,
    output logic                      sdo,
    output logic [DATA_W-1:0]         common_cfg,
    output logic [DATA_W-1:0]         tx_cfg,
    output logic [DATA_W-1:0]         pll_cfg,
    output logic [NCO_BYTES*DATA_W-1:0] nco_freq
);
    logic [2:0]                 sync_q;
    logic [ADDR_W-1:0]          addr;
    logic                       we;
    logic [DATA_W-1:0]          wdata, rdata;
    logic                       out_bit, reading, three_wire;
    logic [NUM_REGS*DATA_W-1:0] regs_flat;

    spi_cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdio_in}), .q(sync_q)
    );

    spi_cfg_engine u_engine (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(sync_q[1]), .cs_n_s(sync_q[2]), .mosi_s(sync_q[0]),
        .rdata(rdata), .addr(addr), .we(we), .wdata(wdata),
        .out_bit(out_bit), .reading(reading)
    );

    spi_cfg_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(addr), .wdata(wdata),
        .raddr(addr), .rdata(rdata), .regs_flat(regs_flat)
    );

    assign three_wire = regs_flat[REG_COMMON*DATA_W + MODE_BIT];
    assign sdio_oe    = three_wire & reading;
    assign sdio_out   = three_wire & reading & out_bit;
    assign sdo        = ~three_wire & reading & out_bit;

    assign common_cfg = regs_flat[REG_COMMON*DATA_W +: DATA_W];
    assign tx_cfg     = regs_flat[REG_TX*DATA_W +: DATA_W];
    assign pll_cfg    = regs_flat[REG_PLL*DATA_W +: DATA_W];
    assign nco_freq   = regs_flat[REG_NCO0*DATA_W +: NCO_BYTES*DATA_W];
endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk
    import spi_cfg_pkg::*;
#(
    parameter int QUIET = 5
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cs_n,
    input logic                          sdio_out,
    input logic                          sdio_oe,
    input logic                          sdo,
    input logic [DATA_W-1:0]             common_cfg,
    input logic [DATA_W-1:0]             tx_cfg,
    input logic [DATA_W-1:0]             pll_cfg,
    input logic [NCO_BYTES*DATA_W-1:0]   nco_freq
);
    logic [3:0] cs_hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cs_hi_cnt <= '0;
        else if (!cs_n)                 cs_hi_cnt <= '0;
        else if (cs_hi_cnt != 4'hF)     cs_hi_cnt <= cs_hi_cnt + 4'd1;
    end

    assert_shared_excludes_sdo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> !sdo);

    assert_four_wire_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !common_cfg[MODE_BIT] |-> !sdio_oe);

    assert_idle_lines_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi_cnt >= 4'(QUIET)) |-> (!sdio_oe && !sdo && !sdio_out));

    assert_idle_regs_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi_cnt > 4'(QUIET)) |-> ($stable(common_cfg) && $stable(tx_cfg)
                                     && $stable(pll_cfg) && $stable(nco_freq)));

    assert_reset_defaults_R7: assert property (@(posedge clk)
        !rst_n |-> (common_cfg == reg_default(REG_COMMON) && tx_cfg == reg_default(REG_TX)
                    && pll_cfg == reg_default(REG_PLL) && nco_freq == 32'h4433_2211));
endmodule

bind spi_cfg_port spi_cfg_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
    .sdo(sdo), .common_cfg(common_cfg), .tx_cfg(tx_cfg), .pll_cfg(pll_cfg),
    .nco_freq(nco_freq)
);

// File: tb/tb_spi_cfg_port.sv
module tb_spi_cfg_port;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdio_in = 1'b0;
    logic sdio_out, sdio_oe, sdo;
    logic [7:0] common_cfg, tx_cfg, pll_cfg;
    logic [31:0] nco_freq;

    int n_cmp = 0;
    int n_bad = 0;
    int oe_err = 0;
    bit finished = 0;
    logic [7:0] wbuf [0:7];
    logic [7:0] rbuf [0:7];

    always #2 clk = ~clk;

    spi_cfg_port dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo),
        .common_cfg(common_cfg), .tx_cfg(tx_cfg), .pll_cfg(pll_cfg), .nco_freq(nco_freq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_h();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic begin_xfer();
        cs_n = 1'b0;
        wait_h();
    endtask

    task automatic end_xfer();
        wait_h();
        cs_n = 1'b1;
        repeat (4) wait_h();
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sdio_in = b[i];
            wait_h();
            sclk = 1'b1;
            wait_h();
            sclk = 1'b0;
        end
    endtask

    task automatic recv_byte(input bit three, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wait_h();
            b[i] = three ? sdio_out : sdo;
            if (three && (sdio_oe !== 1'b1 || sdo !== 1'b0)) oe_err++;
            if (!three && (sdio_oe !== 1'b0 || sdio_out !== 1'b0)) oe_err++;
            sclk = 1'b1;
            wait_h();
            sclk = 1'b0;
        end
    endtask

    task automatic wr_burst(input logic [7:0] instr, input int n);
        begin_xfer();
        send_byte(instr);
        for (int k = 0; k < n; k++) send_byte(wbuf[k]);
        end_xfer();
    endtask

    task automatic rd_burst(input logic [4:0] a, input int n, input bit three);
        logic [7:0] b;
        begin_xfer();
        send_byte({3'b100, a});
        for (int k = 0; k < n; k++) begin
            recv_byte(three, b);
            rbuf[k] = b;
        end
        end_xfer();
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R6: actual hung expected finished");
        summary();
    end

    initial begin
        #1 rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R7 R9: defaults on the parallel fields
        chk("R7 common", {24'h0, common_cfg}, 32'h00);
        chk("R7 tx", {24'h0, tx_cfg}, 32'h87);
        chk("R7 pll", {24'h0, pll_cfg}, 32'h10);
        chk("R9 nco", nco_freq, 32'h4433_2211);
        chk("R6 idle lines", {29'h0, sdio_oe, sdio_out, sdo}, 32'h0);

        // R2 R3 R7: burst read downward from 06h
        oe_err = 0;
        rd_burst(5'h06, 7, 1'b0);
        for (int k = 0; k < 7; k++) begin
            logic [7:0] e;
            e = (k == 6) ? 8'h00 : (k == 5) ? 8'h87 : (k == 4) ? 8'h10 : 8'((4 - k) * 17);
            chk("R3 burst read default order", {24'h0, rbuf[k]}, {24'h0, e});
        end
        chk("R8 four-wire lines during read", oe_err, 0);

        // R1: single write and readback
        wbuf[0] = 8'hA5;
        wr_burst(8'h01, 1);
        chk("R9 tx after write", {24'h0, tx_cfg}, 32'hA5);
        rd_burst(5'h01, 1, 1'b0);
        chk("R1 single readback", {24'h0, rbuf[0]}, 32'hA5);

        // R1: bits 6:5 of the instruction have no effect
        wbuf[0] = 8'h3C;
        wr_burst(8'h62, 1);
        chk("R1 ignored instr bits", {24'h0, pll_cfg}, 32'h3C);

        // R3 R9: burst write assembles the frequency word
        wbuf[0] = 8'hDE; wbuf[1] = 8'hAD; wbuf[2] = 8'hBE; wbuf[3] = 8'hEF;
        wr_burst(8'h06, 4);
        chk("R3 burst write order", nco_freq, 32'hDEAD_BEEF);

        // R4 R5: write across the wrap
        wbuf[0] = 8'h05; wbuf[1] = 8'h77;
        wr_burst(8'h00, 2);
        chk("R4 wrap write 00h", {24'h0, common_cfg}, 32'h05);
        rd_burst(5'h01, 3, 1'b0);
        chk("R4 wrap read 01h", {24'h0, rbuf[0]}, 32'hA5);
        chk("R4 wrap read 00h", {24'h0, rbuf[1]}, 32'h05);
        chk("R4 R5 wrap read 1Fh", {24'h0, rbuf[2]}, 32'h00);

        // R5: unmapped write leaves everything alone
        wbuf[0] = 8'hFF;
        wr_burst(8'h10, 1);
        rd_burst(5'h10, 1, 1'b0);
        chk("R5 unmapped read", {24'h0, rbuf[0]}, 32'h00);
        chk("R5 fields unchanged", {common_cfg, tx_cfg, pll_cfg, 8'h0}, {8'h05, 8'hA5, 8'h3C, 8'h0});
        chk("R5 nco unchanged", nco_freq, 32'hDEAD_BEEF);

        // R6: truncated byte discarded
        begin_xfer();
        send_byte(8'h02);
        for (int i = 0; i < 5; i++) begin
            sdio_in = 1'b1;
            wait_h();
            sclk = 1'b1;
            wait_h();
            sclk = 1'b0;
        end
        end_xfer();
        chk("R6 partial byte", {24'h0, pll_cfg}, 32'h3C);
        rd_burst(5'h02, 1, 1'b0);
        chk("R6 next transfer", {24'h0, rbuf[0]}, 32'h3C);

        // R8: three-wire readback
        wbuf[0] = 8'h80;
        wr_burst(8'h00, 1);
        oe_err = 0;
        rd_burst(5'h03, 2, 1'b1);
        chk("R8 three-wire byte 03h", {24'h0, rbuf[0]}, 32'hEF);
        chk("R8 three-wire byte 02h", {24'h0, rbuf[1]}, 32'h3C);
        chk("R8 three-wire line use", oe_err, 0);
        chk("R6 released after read", {31'h0, sdio_oe}, 32'h0);
        wbuf[0] = 8'h00;
        wr_burst(8'h00, 1);
        oe_err = 0;
        rd_burst(5'h03, 1, 1'b0);
        chk("R8 back to four-wire", {24'h0, rbuf[0]}, 32'hEF);
        chk("R8 four-wire line use", oe_err, 0);

        // R1 R5: sweep every address above 00h
        for (int a = 1; a < 32; a++) begin
            wbuf[0] = 8'((a * 37 + 11) & 255);
            wr_burst(8'(a), 1);
        end
        for (int a = 1; a < 32; a++) begin
            logic [7:0] e;
            e = (a < 7) ? 8'((a * 37 + 11) & 255) : 8'h00;
            rd_burst(5'(a), 1, 1'b0);
            chk("R5 sweep readback", {16'h0, 8'(a), rbuf[0]}, {16'h0, 8'(a), e});
        end

        // R7: reset mid-run restores defaults
        apply_reset();
        chk("R7 reset restore", {common_cfg, tx_cfg, pll_cfg, 8'h0}, {8'h00, 8'h87, 8'h10, 8'h0});
        chk("R7 reset nco", nco_freq, 32'h4433_2211);

        summary();
    end
endmodule